// File: doc/BRIEF.md
# Six-Face Die Counter with Seven-Segment Output

This block is a synchronous counter that steps through the six faces of a die and shows the current face on a single seven-segment digit. A free-running clock advances it by one face per rising edge while the roll enable is high. When the roll enable is released, the face that is showing stays put. The counter counts 1 to 6 and then returns to 1. It never passes through 0 or 7. The return to 1 is a synchronous load of the value 1 that replaces the increment in the cycle after face 6.

The load is triggered by a detector on two bits of the count: bit 1 and bit 2 both set. The same detector also pulls the counter back into range from any power-up value, so the block needs no reset to reach a valid face. An active-low initialise input shares the load path and forces the value 1 on the next edge. A seven-detector looks at the decoded segments and raises a flag when the display shows a 7. The test it uses is segment a lit with segment d dark, which is true for 7 and for no other digit from 0 to 9. In normal use this flag never rises, so it serves as a health indicator.

Top module: `die_roller`

## Requirements
- R1: While `init_n` is high and `roll_en` is high, and `count` does not have bit 1 and bit 2 both set, each rising edge increases `count` by one.
- R2: While `init_n` is high and `roll_en` is low, `count` keeps its value across rising edges, including when the value is 6.
- R3: While `init_n` is high and `roll_en` is high, a `count` with bit 1 and bit 2 both set (6, 7, 14, 15) becomes 1 on the next rising edge instead of incrementing.
- R4: A rising edge with `init_n` low loads `count` with 1, whatever `roll_en` is.
- R5: With `roll_en` held high after initialise, `count` repeats the sequence 1, 2, 3, 4, 5, 6, 1, and so on.
- R6: From any power-up value 0 to 15, with `roll_en` high and no initialise, `count` is within 1 to 6 after at most 7 rising edges. From then on it follows the sequence of R5.
- R7: `seg` is active-high with bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f and bit 6 = g. The values 0 to 9 show as 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F. The values 10 to 15 show 0x00 (blank).
- R8: `seven_flag` is high exactly when `seg` has segment a lit and segment d dark, which happens only when the display shows 7.
- R9: After a rising edge with `init_n` low, `seven_flag` is low and stays low while `init_n` and `roll_en` are driven in any way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; all state changes on its rising edge |
| roll_en | input | 1 | Active-high enable that lets the face advance |
| init_n | input | 1 | Active-low synchronous initialise, loads face 1 |
| count | output | 4 | Current binary count (face value when in range) |
| seg | output | 7 | Active-high segments {g,f,e,d,c,b,a} |
| seven_flag | output | 1 | High when the displayed digit is a 7 |

## Verification
The assertions assume that `roll_en` and `init_n` are always 0 or 1, never unknown, and that they change only away from the rising edge. They also assume that the count register holds a defined power-up value. Before the first edge they check nothing, because no earlier value exists to compare against. The bench changes its inputs only on the falling edge. It sets the power-up value of each instance through a parameter, so every one of the sixteen start states is a known value. This makes out-of-range recovery visible without any reset being applied.

// File: rtl/die_pkg.sv
// Package: shared types and constants for the die counter.
// Assumes a 4-bit count and a 7-segment display with segment a in bit 0.
package die_pkg;
    localparam int CNT_W = 4;
    localparam int SEG_W = 7;
    typedef logic [CNT_W-1:0] count_t;
    typedef logic [SEG_W-1:0] seg_t;
    // Value loaded on wrap-around and on initialise
    localparam count_t LOAD_VAL = count_t'(1);
    // Bits that must all be set to request a reload (bits 1 and 2)
    localparam count_t DETECT_MASK = count_t'(6);
    // Segment bit positions used by the seven-detector
    localparam int SEG_A = 0;
    localparam int SEG_D = 3;
endpackage

// File: rtl/die_next.sv
// Module: next-state logic for the die counter.
// Forms the active-low load request from the bit detector and the
// initialise input, then picks load, increment or hold.
// Assumes inputs are known; purely combinational.
module die_next
    import die_pkg::*;
(
    input  count_t cur,
    input  logic   roll_en,
    input  logic   init_n,
    output count_t nxt,
    output logic   load_req_n
);
    logic detect;

    // Detector: all masked count bits set, gated by the roll enable
    always_comb detect = ((cur & DETECT_MASK) == DETECT_MASK) && roll_en;

    // Low-active OR of detector and initialise into one load request
    always_comb load_req_n = ~(detect | ~init_n);

    // Select the next count: load, advance or hold
    always_comb begin
        if (!load_req_n)
            nxt = LOAD_VAL;
        else if (roll_en)
            nxt = cur + count_t'(1);
        else
            nxt = cur;
    end
endmodule

// File: rtl/die_seg_decode.sv
// Module: binary to active-high 7-segment decoder.
// Output order {g,f,e,d,c,b,a}; values above 9 blank the digit.
module die_seg_decode
    import die_pkg::*;
(
    input  count_t value,
    output seg_t   seg
);
    // Map each decimal digit to its lit segments
    always_comb begin
        case (value)
            count_t'(0): seg = 7'h3F;
            count_t'(1): seg = 7'h06;
            count_t'(2): seg = 7'h5B;
            count_t'(3): seg = 7'h4F;
            count_t'(4): seg = 7'h66;
            count_t'(5): seg = 7'h6D;
            count_t'(6): seg = 7'h7D;
            count_t'(7): seg = 7'h07;
            count_t'(8): seg = 7'h7F;
            count_t'(9): seg = 7'h6F;
            default:     seg = 7'h00;
        endcase
    end
endmodule

// File: rtl/die_seven_detect.sv
// Module: recognises a displayed 7 from segments alone.
// Segment a lit with segment d dark is unique to 7 among 0..9;
// a, b and c together would also match 3, so they are not used.
module die_seven_detect
    import die_pkg::*;
(
    input  seg_t seg,
    output logic is_seven
);
    // Flag the a-on, d-off combination
    always_comb is_seven = seg[SEG_A] & ~seg[SEG_D];
endmodule

// File: rtl/die_roller.sv
// Module: top of the die counter.
// One clock domain, no asynchronous reset. POWERUP sets the register's
// power-up content so recovery from any state can be exercised; init_n
// is the synchronous active-low initialise.
module die_roller #(
    parameter logic [3:0] POWERUP = 4'd0
) (
    input  logic       clk,
    input  logic       roll_en,
    input  logic       init_n,
    output logic [3:0] count,
    output logic [6:0] seg,
    output logic       seven_flag
);
    import die_pkg::*;

    count_t count_q = count_t'(POWERUP);
    count_t count_d;
    logic   load_req_n;

    die_next u_next (
        .cur        (count_q),
        .roll_en    (roll_en),
        .init_n     (init_n),
        .nxt        (count_d),
        .load_req_n (load_req_n)
    );

    // Count register: takes the selected next value every edge
    always_ff @(posedge clk) begin
        count_q <= count_d;
    end

    die_seg_decode u_dec (
        .value (count_q),
        .seg   (seg)
    );

    die_seven_detect u_seven (
        .seg      (seg),
        .is_seven (seven_flag)
    );

    // Present the register value at the port
    always_comb count = count_q;
endmodule

// File: rtl/die_roller_chk.sv
// Checker: temporal properties of the die counter, bound to the top.
// Armed only after the first edge so that $past always has history.
module die_roller_chk (
    input logic       clk,
    input logic       roll_en,
    input logic       init_n,
    input logic [3:0] count,
    input logic [6:0] seg,
    input logic       seven_flag
);
    logic armed_q = 1'b0;
    logic clean_q = 1'b0;

    // Arm after the first clock edge
    always_ff @(posedge clk) armed_q <= 1'b1;

    // Track whether an initialise has been seen
    always_ff @(posedge clk) if (!init_n) clean_q <= 1'b1;

    a_r1_advance: assert property (@(posedge clk) disable iff (!armed_q)
        (init_n && roll_en && !(count[1] && count[2])) |=> (count == $past(count) + 4'd1));

    a_r2_hold: assert property (@(posedge clk) disable iff (!armed_q)
        (init_n && !roll_en) |=> $stable(count));

    a_r3_reload: assert property (@(posedge clk) disable iff (!armed_q)
        (init_n && roll_en && count[1] && count[2]) |=> (count == 4'd1));

    a_r4_init: assert property (@(posedge clk) disable iff (!armed_q)
        !init_n |=> (count == 4'd1));

    a_r7_blank: assert property (@(posedge clk) disable iff (!armed_q)
        (count > 4'd9) |-> (seg == 7'h00));

    a_r8_flag: assert property (@(posedge clk) disable iff (!armed_q)
        seven_flag == (count == 4'd7));

    a_r9_no_seven: assert property (@(posedge clk) disable iff (!armed_q)
        clean_q |-> !seven_flag);
endmodule

bind die_roller die_roller_chk u_chk (
    .clk        (clk),
    .roll_en    (roll_en),
    .init_n     (init_n),
    .count      (count),
    .seg        (seg),
    .seven_flag (seven_flag)
);

// File: tb/die_roller_test.sv
module die_roller_test;
    logic clk = 1'b0;
    logic roll_en = 1'b0;
    logic init_n = 1'b1;
    logic [3:0] count;
    logic [6:0] seg;
    logic seven_flag;
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    die_roller uut (
        .clk(clk), .roll_en(roll_en), .init_n(init_n),
        .count(count), .seg(seg), .seven_flag(seven_flag)
    );

    logic [3:0] sw_cnt [16];
    logic [6:0] sw_seg [16];
    logic       sw_flag [16];
    logic       sw_en = 1'b1;
    logic       sw_init_n = 1'b1;

    for (genvar i = 0; i < 16; i++) begin : g_sweep
        die_roller #(.POWERUP(4'(i))) dut (
            .clk(clk), .roll_en(sw_en), .init_n(sw_init_n),
            .count(sw_cnt[i]), .seg(sw_seg[i]), .seven_flag(sw_flag[i])
        );
    end

    function automatic logic [6:0] exp_seg(input logic [3:0] v);
        case (v)
            4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
            4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
            4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
            4'd9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [3:0] exp_next(input logic [3:0] v, input logic en, input logic ini_n);
        if (!ini_n) return 4'd1;
        if (!en) return v;
        if (v[1] && v[2]) return 4'd1;
        return v + 4'd1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string req, input logic [3:0] e);
        check(req, count, e);
        check({req, " R7 seg"}, seg, exp_seg(e));
        check({req, " R8 flag"}, seven_flag, (e == 4'd7));
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] model [16];
        logic [3:0] e;
        // Sweep: every power-up value, roll enabled, no initialise (R6, R3, R7, R8)
        #1;
        for (int i = 0; i < 16; i++) model[i] = 4'(i);
        for (int step = 0; step <= 10; step++) begin
            for (int i = 0; i < 16; i++) begin
                check("R6 sweep count", sw_cnt[i], model[i]);
                check("R7 sweep seg", sw_seg[i], exp_seg(model[i]));
                check("R8 sweep flag", sw_flag[i], (model[i] == 4'd7));
                if (step >= 7) check("R6 in range", (sw_cnt[i] >= 1 && sw_cnt[i] <= 6), 1);
            end
            @(posedge clk);
            #1;
            for (int i = 0; i < 16; i++) model[i] = exp_next(model[i], 1'b1, 1'b1);
        end
        // Values 7, 14, 15 reload directly (R3): checked via model above
        @(negedge clk);

        // Initialise with roll disabled (R4, R9)
        init_n = 1'b0; roll_en = 1'b0;
        tick();
        check_all("R4 init", 4'd1);
        init_n = 1'b1;

        // Running cycle (R1, R3, R5, R9)
        e = 4'd1;
        roll_en = 1'b1;
        for (int k = 0; k < 60; k++) begin
            tick();
            e = exp_next(e, 1'b1, 1'b1);
            check_all("R5 cycle", e);
            check("R9 no seven", seven_flag, 0);
        end

        // Hold at each face, including 6 (R2)
        for (int f = 0; f < 6; f++) begin
            roll_en = 1'b0;
            for (int k = 0; k < 3; k++) begin
                tick();
                check_all("R2 hold", e);
            end
            roll_en = 1'b1;
            tick();
            e = exp_next(e, 1'b1, 1'b1);
            check_all("R1 advance", e);
        end

        // Initialise mid-count with roll enabled (R4)
        while (e != 4'd4) begin
            tick();
            e = exp_next(e, 1'b1, 1'b1);
        end
        check_all("R1 reach4", e);
        init_n = 1'b0;
        tick();
        check_all("R4 init while rolling", 4'd1);
        tick();
        check_all("R4 init held", 4'd1);
        init_n = 1'b1;
        tick();
        check_all("R1 after init", 4'd2);
        check("R9 no seven", seven_flag, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule